// File: doc/BRIEF.md
# Register Read-After-Write Stall Unit

This unit sits beside the decode stage of a five-stage in-order pipeline. It works out whether the instruction now in decode reads a register that an older instruction in flight has not yet written back. When that is so, it freezes the front end for one cycle and sends an empty slot down the pipe in place of the decoded instruction. It asks for a stall again each cycle until the dependency is gone. All checks are made while the consumer sits in decode, before it issues to execute.

The choice of detection scheme is fixed when the block is built, by the `MODE` parameter. With `MODE = 0`, destination/source comparators look at the three later pipeline registers (decode/execute, execute/memory, memory/writeback). There is no forwarding, so any match stalls. With `MODE = 1`, a per-register pending-write scoreboard is used. A bit is marked when a writing instruction leaves decode and is released when that instruction reaches the memory/writeback register. Decode stalls while either of its sources is marked.

Internally, a cause encoder (one of the two detectors, picked by a generate branch) reports a named hazard cause: `HZ_CLEAR`, `HZ_EXEC`, `HZ_MEMACC`, `HZ_WBACK` or `HZ_BUSY`. A stall controller maps that cause to the three front-end controls. It has two decision states, named in the package. `ST_FLOW` lets the PC and the fetch/decode register advance. `ST_HOLD` freezes both and zeroes the control fields entering execute. Reset forces `ST_FLOW`. Every cause other than `HZ_CLEAR` selects `ST_HOLD`, and `HZ_CLEAR` selects `ST_FLOW`.

Top module: `raw_stall_unit`

## Requirements
- R1: In comparator mode, when `idex_regwrite` is 1, the decode/execute destination is `idex_rt` if `idex_regdst` is 0 and `idex_rd` if it is 1. If that destination is nonzero and equals `ifid_rs` or `ifid_rt`, a stall is raised in the same cycle.
- R2: In comparator mode, when `exmem_regwrite` is 1 and a nonzero `exmem_dst` equals `ifid_rs` or `ifid_rt`, a stall is raised in the same cycle.
- R3: In comparator mode, when `memwb_regwrite` is 1 and a nonzero `memwb_dst` equals `ifid_rs` or `ifid_rt`, a stall is raised in the same cycle.
- R4: During a stall, `bubble` is 1 and `pc_write` and `ifid_write` are 0. Otherwise `bubble` is 0 and `pc_write` and `ifid_write` are 1. The outputs respond combinationally in the cycle the hazard is present.
- R5: In scoreboard mode, a clock edge at which `id_regwrite` is 1, `id_dst` is nonzero and no stall is raised marks `id_dst` as busy. From the next cycle on, decode stalls if `ifid_rs` or `ifid_rt` names a busy register.
- R6: In scoreboard mode, a clock edge at which `memwb_regwrite` is 1 releases `memwb_dst`. From the next cycle on, reading that register causes no stall.
- R7: In scoreboard mode, if the same register is marked and released at one edge, it ends up busy.
- R8: Register 0 never causes a stall. In scoreboard mode, an instruction stalled in decode marks nothing.
- R9: While the synchronous reset `rst` is 1, `pc_write` and `ifid_write` are 1 and `bubble` is 0. After reset, every scoreboard bit is clear.
- R10: In comparator mode, a stage whose write enable is 0 never causes a stall. The decode/execute register field that `idex_regdst` does not select has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ifid_rs | input | REG_W | First source register of the decode instruction |
| ifid_rt | input | REG_W | Second source register of the decode instruction |
| idex_regwrite | input | 1 | Decode/execute instruction writes a register |
| idex_regdst | input | 1 | Destination select: 0 picks `idex_rt`, 1 picks `idex_rd` |
| idex_rt | input | REG_W | Decode/execute rt field |
| idex_rd | input | REG_W | Decode/execute rd field |
| exmem_regwrite | input | 1 | Execute/memory instruction writes a register |
| exmem_dst | input | REG_W | Execute/memory destination register |
| memwb_regwrite | input | 1 | Memory/writeback instruction writes a register |
| memwb_dst | input | REG_W | Memory/writeback destination register |
| id_regwrite | input | 1 | Decode instruction will write a register (scoreboard mode) |
| id_dst | input | REG_W | Decoded destination of the decode instruction (scoreboard mode) |
| pc_write | output | 1 | PC update enable |
| ifid_write | output | 1 | Fetch/decode register update enable |
| bubble | output | 1 | Zero the control fields entering decode/execute |

## Verification
In scoreboard mode, a busy bit can be marked by the issuing instruction and released by the retiring one at the same edge. Both may also name the same register. The bench provokes this on purpose with a directed step and draws random destinations from only four registers, so that it recurs many times. It judges the result in the following cycle by reading that register as a source and expecting a stall. It also checks that a stalled decode instruction's destination stays free, and that comparator hits from several stages at once still give a single clean stall.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

    typedef enum logic [2:0] {
        HZ_CLEAR  = 3'd0,
        HZ_EXEC   = 3'd1,
        HZ_MEMACC = 3'd2,
        HZ_WBACK  = 3'd3,
        HZ_BUSY   = 3'd4
    } hz_cause_e;

    typedef enum logic {
        ST_FLOW = 1'b0,
        ST_HOLD = 1'b1
    } front_state_e;

endpackage

// File: rtl/cmp_detect.sv
module cmp_detect
    import hazard_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    input  logic             ex_we,
    input  logic             ex_sel_rd,
    input  logic [REG_W-1:0] ex_rt,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             mem_we,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             wb_we,
    input  logic [REG_W-1:0] wb_dst,
    output hz_cause_e        cause
);

    function automatic logic reads_dst(input logic [REG_W-1:0] d,
                                       input logic [REG_W-1:0] a,
                                       input logic [REG_W-1:0] b);
        return (d != '0) && ((d == a) || (d == b));
    endfunction

    logic [REG_W-1:0] ex_dst;
    logic             hit_ex, hit_mem, hit_wb;

    assign ex_dst  = ex_sel_rd ? ex_rd : ex_rt;
    assign hit_ex  = ex_we  && reads_dst(ex_dst,  src_a, src_b);
    assign hit_mem = mem_we && reads_dst(mem_dst, src_a, src_b);
    assign hit_wb  = wb_we  && reads_dst(wb_dst,  src_a, src_b);

    always_comb begin
        if (hit_ex)       cause = HZ_EXEC;
        else if (hit_mem) cause = HZ_MEMACC;
        else if (hit_wb)  cause = HZ_WBACK;
        else              cause = HZ_CLEAR;
    end

endmodule

// File: rtl/busy_board.sv
module busy_board
    import hazard_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    input  logic             issue_en,
    input  logic [REG_W-1:0] issue_dst,
    input  logic             retire_en,
    input  logic [REG_W-1:0] retire_dst,
    output hz_cause_e        cause
);

    localparam int NREG = 1 << REG_W;

    logic [NREG-1:0] pending;

    assign pending[0] = 1'b0;

    for (genvar g = 1; g < NREG; g++) begin : g_bit
        logic mark, release_now;
        assign mark        = issue_en  && (issue_dst  == REG_W'(g));
        assign release_now = retire_en && (retire_dst == REG_W'(g));
        always_ff @(posedge clk) begin
            if (rst)               pending[g] <= 1'b0;
            else if (mark)         pending[g] <= 1'b1;
            else if (release_now)  pending[g] <= 1'b0;
        end
    end

    always_comb begin
        if (pending[src_a] || pending[src_b]) cause = HZ_BUSY;
        else                                  cause = HZ_CLEAR;
    end

endmodule

// File: rtl/stall_ctrl.sv
module stall_ctrl
    import hazard_pkg::*;
(
    input  logic      rst,
    input  hz_cause_e cause,
    output logic      pc_we,
    output logic      fd_we,
    output logic      kill_ctl
);

    front_state_e state;

    always_comb begin
        if (rst) begin
            state = ST_FLOW;
        end else begin
            unique case (cause)
                HZ_CLEAR:  state = ST_FLOW;
                HZ_EXEC,
                HZ_MEMACC,
                HZ_WBACK,
                HZ_BUSY:   state = ST_HOLD;
                default:   state = ST_HOLD;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_FLOW: begin
                pc_we    = 1'b1;
                fd_we    = 1'b1;
                kill_ctl = 1'b0;
            end
            ST_HOLD: begin
                pc_we    = 1'b0;
                fd_we    = 1'b0;
                kill_ctl = 1'b1;
            end
            default: begin
                pc_we    = 1'b0;
                fd_we    = 1'b0;
                kill_ctl = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/raw_stall_unit.sv
module raw_stall_unit
    import hazard_pkg::*;
#(
    parameter int MODE  = 0,
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] ifid_rs,
    input  logic [REG_W-1:0] ifid_rt,
    input  logic             idex_regwrite,
    input  logic             idex_regdst,
    input  logic [REG_W-1:0] idex_rt,
    input  logic [REG_W-1:0] idex_rd,
    input  logic             exmem_regwrite,
    input  logic [REG_W-1:0] exmem_dst,
    input  logic             memwb_regwrite,
    input  logic [REG_W-1:0] memwb_dst,
    input  logic             id_regwrite,
    input  logic [REG_W-1:0] id_dst,
    output logic             pc_write,
    output logic             ifid_write,
    output logic             bubble
);

    hz_cause_e cause;

    if (MODE == 0) begin : g_cmp
        logic unused_sb;
        assign unused_sb = ^{clk, id_regwrite, id_dst};

        cmp_detect #(.REG_W(REG_W)) u_cmp (
            .src_a     (ifid_rs),
            .src_b     (ifid_rt),
            .ex_we     (idex_regwrite),
            .ex_sel_rd (idex_regdst),
            .ex_rt     (idex_rt),
            .ex_rd     (idex_rd),
            .mem_we    (exmem_regwrite),
            .mem_dst   (exmem_dst),
            .wb_we     (memwb_regwrite),
            .wb_dst    (memwb_dst),
            .cause     (cause)
        );
    end else begin : g_board
        logic unused_cmp;
        logic issue_ok;
        assign unused_cmp = ^{idex_regwrite, idex_regdst, idex_rt, idex_rd,
                              exmem_regwrite, exmem_dst};
        assign issue_ok   = id_regwrite && !bubble;

        busy_board #(.REG_W(REG_W)) u_board (
            .clk        (clk),
            .rst        (rst),
            .src_a      (ifid_rs),
            .src_b      (ifid_rt),
            .issue_en   (issue_ok),
            .issue_dst  (id_dst),
            .retire_en  (memwb_regwrite),
            .retire_dst (memwb_dst),
            .cause      (cause)
        );
    end

    stall_ctrl u_ctrl (
        .rst      (rst),
        .cause    (cause),
        .pc_we    (pc_write),
        .fd_we    (ifid_write),
        .kill_ctl (bubble)
    );

endmodule

// File: rtl/raw_stall_checks.sv
module raw_stall_checks #(
    parameter int MODE  = 0,
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [REG_W-1:0] ifid_rs,
    input logic [REG_W-1:0] ifid_rt,
    input logic             idex_regwrite,
    input logic             idex_regdst,
    input logic [REG_W-1:0] idex_rt,
    input logic [REG_W-1:0] idex_rd,
    input logic             exmem_regwrite,
    input logic [REG_W-1:0] exmem_dst,
    input logic             memwb_regwrite,
    input logic [REG_W-1:0] memwb_dst,
    input logic             id_regwrite,
    input logic [REG_W-1:0] id_dst,
    input logic             pc_write,
    input logic             ifid_write,
    input logic             bubble
);

    assert_hold_front_R4: assert property (@(posedge clk) disable iff (rst)
        bubble |-> (!pc_write && !ifid_write));

    assert_free_front_R4: assert property (@(posedge clk) disable iff (rst)
        !bubble |-> (pc_write && ifid_write));

    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |-> (pc_write && ifid_write && !bubble));

    assert_zero_src_R8: assert property (@(posedge clk) disable iff (rst)
        (ifid_rs == '0 && ifid_rt == '0) |-> !bubble);

    if (MODE == 0) begin : g_cmp_props
        assert_idex_rd_R1: assert property (@(posedge clk) disable iff (rst)
            (idex_regwrite && idex_regdst && idex_rd != '0 && idex_rd == ifid_rs)
            |-> bubble);

        assert_exmem_R2: assert property (@(posedge clk) disable iff (rst)
            (exmem_regwrite && exmem_dst != '0 && exmem_dst == ifid_rt) |-> bubble);

        assert_memwb_R3: assert property (@(posedge clk) disable iff (rst)
            (memwb_regwrite && memwb_dst != '0 && memwb_dst == ifid_rs) |-> bubble);

        assert_no_writer_R10: assert property (@(posedge clk) disable iff (rst)
            (!idex_regwrite && !exmem_regwrite && !memwb_regwrite) |-> !bubble);
    end else begin : g_board_props
        assert_clear_after_reset_R9: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> !bubble);

        assert_issue_marks_R5: assert property (@(posedge clk) disable iff (rst)
            (!bubble && id_regwrite && id_dst != '0)
            |=> ((ifid_rs == $past(id_dst)) |-> bubble));

        assert_retire_frees_R6: assert property (@(posedge clk) disable iff (rst)
            (memwb_regwrite && memwb_dst != '0 &&
             !(id_regwrite && !bubble && id_dst == memwb_dst))
            |=> ((ifid_rs == $past(memwb_dst) && ifid_rt == $past(memwb_dst))
                 |-> !bubble));
    end

endmodule

bind raw_stall_unit raw_stall_checks #(.MODE(MODE), .REG_W(REG_W)) u_chk (.*);

// File: tb/sim_raw_stall_unit.sv
module sim_raw_stall_unit;

    localparam int CLK_PERIOD = 10;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic [RW-1:0] ifid_rs, ifid_rt, idex_rt, idex_rd, exmem_dst, memwb_dst, id_dst;
    logic          idex_regwrite, idex_regdst, exmem_regwrite, memwb_regwrite, id_regwrite;
    logic          pcw0, fdw0, bub0, pcw1, fdw1, bub1;

    int checks   = 0;
    int failures = 0;
    logic [31:0] busy_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    raw_stall_unit #(.MODE(0), .REG_W(RW)) u0 (
        .clk(clk), .rst(rst), .ifid_rs(ifid_rs), .ifid_rt(ifid_rt),
        .idex_regwrite(idex_regwrite), .idex_regdst(idex_regdst),
        .idex_rt(idex_rt), .idex_rd(idex_rd),
        .exmem_regwrite(exmem_regwrite), .exmem_dst(exmem_dst),
        .memwb_regwrite(memwb_regwrite), .memwb_dst(memwb_dst),
        .id_regwrite(id_regwrite), .id_dst(id_dst),
        .pc_write(pcw0), .ifid_write(fdw0), .bubble(bub0));

    raw_stall_unit #(.MODE(1), .REG_W(RW)) u1 (
        .clk(clk), .rst(rst), .ifid_rs(ifid_rs), .ifid_rt(ifid_rt),
        .idex_regwrite(idex_regwrite), .idex_regdst(idex_regdst),
        .idex_rt(idex_rt), .idex_rd(idex_rd),
        .exmem_regwrite(exmem_regwrite), .exmem_dst(exmem_dst),
        .memwb_regwrite(memwb_regwrite), .memwb_dst(memwb_dst),
        .id_regwrite(id_regwrite), .id_dst(id_dst),
        .pc_write(pcw1), .ifid_write(fdw1), .bubble(bub1));

    function automatic logic hit(input logic [RW-1:0] d);
        return (d != '0) && (d == ifid_rs || d == ifid_rt);
    endfunction

    function automatic logic exp_cmp();
        logic [RW-1:0] exd;
        if (rst) return 1'b0;
        exd = idex_regdst ? idex_rd : idex_rt;
        return (idex_regwrite && hit(exd)) || (exmem_regwrite && hit(exmem_dst)) ||
               (memwb_regwrite && hit(memwb_dst));
    endfunction

    function automatic logic exp_sb();
        if (rst) return 1'b0;
        return (ifid_rs != '0 && busy_m[ifid_rs]) || (ifid_rt != '0 && busy_m[ifid_rt]);
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic zero_in();
        ifid_rs = '0; ifid_rt = '0; idex_regwrite = 0; idex_regdst = 0;
        idex_rt = '0; idex_rd = '0; exmem_regwrite = 0; exmem_dst = '0;
        memwb_regwrite = 0; memwb_dst = '0; id_regwrite = 0; id_dst = '0;
    endtask

    // Inputs are driven at the falling edge before calling; checks sample 1 time unit later.
    task automatic step(input string tag_c, input string tag_s);
        logic ec, es;
        #1;
        ec = exp_cmp();
        es = exp_sb();
        chk(tag_c, "cmp bubble", bub0, ec);
        chk("R4", "cmp pc_write", pcw0, !ec);
        chk("R4", "cmp ifid_write", fdw0, !ec);
        chk(tag_s, "sb bubble", bub1, es);
        chk("R4", "sb ifid_write", fdw1, !es);
        @(posedge clk);
        if (rst) busy_m = '0;
        else begin
            if (memwb_regwrite) busy_m[memwb_dst] = 1'b0;
            if (id_regwrite && !es && id_dst != '0) busy_m[id_dst] = 1'b1;
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        busy_m = '0;
        rst = 1'b1;
        zero_in();
        @(negedge clk);
        // R9: outputs quiet in reset even with hazards present
        ifid_rs = 5'd3; idex_regwrite = 1; idex_rt = 5'd3;
        id_regwrite = 1; id_dst = 5'd3;
        step("R9", "R9");
        rst = 1'b0;
        zero_in();
        ifid_rs = 5'd3;
        step("R9", "R9");

        // R1: rt selected, then rd selected
        zero_in(); ifid_rs = 5'd7; idex_regwrite = 1; idex_regdst = 0; idex_rt = 5'd7; idex_rd = 5'd9;
        step("R1", "R5");
        idex_regdst = 1; idex_rd = 5'd7; idex_rt = 5'd2; ifid_rs = 5'd1; ifid_rt = 5'd7;
        step("R1", "R5");
        // R10: unselected field matches, selected does not
        idex_regdst = 1; idex_rd = 5'd4; idex_rt = 5'd7;
        step("R10", "R5");
        // R10: stages not writing
        zero_in(); ifid_rs = 5'd6; ifid_rt = 5'd6; idex_rt = 5'd6; idex_rd = 5'd6;
        exmem_dst = 5'd6; memwb_dst = 5'd6;
        step("R10", "R6");
        // R2, R3
        zero_in(); ifid_rt = 5'd12; exmem_regwrite = 1; exmem_dst = 5'd12;
        step("R2", "R5");
        zero_in(); ifid_rs = 5'd13; memwb_regwrite = 1; memwb_dst = 5'd13;
        step("R3", "R6");
        // R8: register 0 everywhere
        zero_in(); idex_regwrite = 1; exmem_regwrite = 1; memwb_regwrite = 1;
        id_regwrite = 1;
        step("R8", "R8");
        zero_in();
        step("R8", "R8");

        // R5: mark reg 5, then read it
        zero_in(); id_regwrite = 1; id_dst = 5'd5;
        step("R5", "R5");
        zero_in(); ifid_rs = 5'd5;
        step("R5", "R5");
        // R7: mark and release reg 5 at one edge
        zero_in(); id_regwrite = 1; id_dst = 5'd5; memwb_regwrite = 1; memwb_dst = 5'd5;
        step("R7", "R7");
        zero_in(); ifid_rt = 5'd5;
        step("R7", "R7");
        // R8: stalled decode (reads busy 5) must not mark 6
        zero_in(); ifid_rs = 5'd5; id_regwrite = 1; id_dst = 5'd6;
        step("R8", "R8");
        zero_in(); ifid_rs = 5'd6; ifid_rt = 5'd6;
        step("R8", "R8");
        // R6: release 5
        zero_in(); memwb_regwrite = 1; memwb_dst = 5'd5;
        step("R6", "R6");
        zero_in(); ifid_rs = 5'd5;
        step("R6", "R6");

        // random mix over a small register window
        for (int i = 0; i < 4000; i++) begin
            ifid_rs = RW'($urandom_range(3)); ifid_rt = RW'($urandom_range(3));
            idex_regwrite = 1'($urandom); idex_regdst = 1'($urandom);
            idex_rt = RW'($urandom_range(3)); idex_rd = RW'($urandom_range(3));
            exmem_regwrite = 1'($urandom); exmem_dst = RW'($urandom_range(3));
            memwb_regwrite = 1'($urandom); memwb_dst = RW'($urandom_range(3));
            id_regwrite = 1'($urandom); id_dst = RW'($urandom_range(3));
            step("R1", "R7");
        end

        // R9: reset in the middle clears busy bits
        zero_in(); id_regwrite = 1; id_dst = 5'd2;
        step("R5", "R5");
        zero_in(); rst = 1'b1; ifid_rs = 5'd2;
        step("R9", "R9");
        rst = 1'b0;
        step("R9", "R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule